// File: doc/BRIEF.md
# Day and seconds real-time counter

This block keeps wall time as two binary counts. One is a 17-bit seconds-of-day count that runs from 0 to 86399. The other is a 15-bit day count. A slow-clock enable (nominally 32768 Hz) feeds a prescaler, and each time the prescaler completes one second the time advances by one. A matching alarm is compared against the time on every tick. A once-per-second update flag is also set on every tick.

Software sees eight 16-bit registers through a simple bus with address, write data, write enable and combinational read data. The seconds count is split into a low byte and a 9-bit high part. To set the time, software writes the day, then the high part, then the low byte. The low-byte write also restarts the prescaler, so the complete new time runs from that write. Each interrupt source has a sticky status flag, cleared by writing 1, and its own mask bit. Each interrupt output is high while its flag and its mask bit are both set.

Register addresses: 0 seconds low (bits 7:0 of the seconds count), 1 seconds high (bits 16:8), 2 day, 3 alarm seconds low, 4 alarm seconds high, 5 alarm day, 6 status, 7 mask.

Top module: `sec_day_rtc`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The time advances by one second after every PRESCALE cycles in which slowEn is high. In the tick that leaves seconds 86399 (or any higher value), the seconds count becomes 0 and the day count rises by one, both in the same clock cycle.
- R3: The day count wraps from 0x7FFF to 0 at a day rollover.
- R4: The seconds high register (address 1, bits 8:0) changes on a tick only when the low byte (address 0, bits 7:0) rolls from 0xFF to 0x00, or at a day rollover.
- R5: A write to address 0 sets the prescaler to zero and suppresses any tick in that cycle. The next tick follows exactly PRESCALE slowEn cycles later. A written value reads back on the next cycle. A write to address 1 or 2 in a tick cycle overrides that field.
- R6: The alarm registers at addresses 3, 4 and 5 use the same 8/9/15-bit layout as addresses 0, 1 and 2, and they read back what was written.
- R7: On a tick whose new day and seconds equal the alarm day and seconds, status bit 0 (the alarm flag) sets. It sets only on that tick, and it does not set again while the time moves past the alarm.
- R8: Every tick sets status bit 1 (the update flag).
- R9: Status flags hold until software writes 1 to their bit at address 6. A set in the same cycle wins over the clear. alarmIrq equals status bit 0 AND mask bit 0 (address 7). tickIrq equals status bit 1 AND mask bit 1.
- R10: Register bits above each field width read as 0, and writes to them are ignored. The widths are 8, 9 and 15 bits for the time and alarm fields and 2 bits for status and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowEn | input | 1 | Slow-clock enable pulse fed to the prescaler |
| addr | input | 3 | Register address |
| wData | input | 16 | Write data |
| wEn | input | 1 | Write strobe for the addressed register |
| rData | output | 16 | Read data for the addressed register (combinational) |
| alarmIrq | output | 1 | Alarm interrupt, level |
| tickIrq | output | 1 | Once-per-second update interrupt, level |

## Verification
A wrong prescaler count shows up as the seconds low byte changing one or more slowEn cycles early or late. A restart that was skipped on a low-byte write shows up as an early increment within the first second after the write. A bad carry or rollover shows up in the seconds high or day readback on the very tick where it happens. A wrong alarm compare, or a wrong sticky/clear rule, appears at alarmIrq and status on the cycle after the matching tick or after the clearing write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int LO_W    = 8;
  localparam int HI_W    = 9;
  localparam int SEC_W   = LO_W + HI_W;
  localparam int DAY_W   = 15;
  localparam int FLAG_W  = 2;
  localparam int NREG    = 1 << ADDR_W;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(86399);

  typedef enum logic [ADDR_W-1:0] {
    A_SEC_LO  = 3'd0,
    A_SEC_HI  = 3'd1,
    A_DAY     = 3'd2,
    A_ALM_LO  = 3'd3,
    A_ALM_HI  = 3'd4,
    A_ALM_DAY = 3'd5,
    A_STAT    = 3'd6,
    A_MASK    = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic tick;
    logic wrSecLo;
    logic wrSecHi;
    logic wrDay;
    logic wrAlmLo;
    logic wrAlmHi;
    logic wrAlmDay;
    logic wrStat;
    logic wrMask;
  } strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wEn,
  output strobe_t           stb
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PRESCALE - 1);

  logic [NREG-1:0]  sel;
  logic [CNT_W-1:0] presc;
  logic             atLast;

  always_comb begin
    sel = '0;
    if (wEn) sel = NREG'(1) << addr;
  end

  assign atLast = (presc == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN)                 presc <= '0;
    else if (sel[A_SEC_LO])    presc <= '0;
    else if (slowEn && atLast) presc <= '0;
    else if (slowEn)           presc <= presc + 1'b1;
  end

  always_comb begin
    stb.tick     = slowEn && atLast && !sel[A_SEC_LO];
    stb.wrSecLo  = sel[A_SEC_LO];
    stb.wrSecHi  = sel[A_SEC_HI];
    stb.wrDay    = sel[A_DAY];
    stb.wrAlmLo  = sel[A_ALM_LO];
    stb.wrAlmHi  = sel[A_ALM_HI];
    stb.wrAlmDay = sel[A_ALM_DAY];
    stb.wrStat   = sel[A_STAT];
    stb.wrMask   = sel[A_MASK];
  end
endmodule

// File: rtl/rtc_dpath.sv
module rtc_dpath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic [SEC_W-1:0]  secOut,
  output logic [DAY_W-1:0]  dayOut,
  output logic [FLAG_W-1:0] flagOut,
  output logic              alarmIrq,
  output logic              tickIrq
);
  logic [SEC_W-1:0]  sec, almSec, incSec, nextSec;
  logic [DAY_W-1:0]  day, almDay, incDay, nextDay;
  logic [FLAG_W-1:0] flags, mask, setV, clrV;
  logic              alarmHit;

  always_comb begin
    if (sec >= LAST_SEC) begin
      incSec = '0;
      incDay = day + 1'b1;
    end else begin
      incSec = sec + 1'b1;
      incDay = day;
    end
    nextSec = stb.tick ? incSec : sec;
    nextDay = stb.tick ? incDay : day;
    if (stb.wrSecLo) nextSec[LO_W-1:0] = wData[LO_W-1:0];
    if (stb.wrSecHi) nextSec[SEC_W-1:LO_W] = wData[HI_W-1:0];
    if (stb.wrDay)   nextDay = wData[DAY_W-1:0];
  end

  assign alarmHit = stb.tick && (incSec == almSec) && (incDay == almDay);
  assign setV     = {stb.tick, alarmHit};
  assign clrV     = stb.wrStat ? wData[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec    <= '0;
      day    <= '0;
      almSec <= '0;
      almDay <= '0;
      flags  <= '0;
      mask   <= '0;
    end else begin
      sec   <= nextSec;
      day   <= nextDay;
      flags <= (flags & ~clrV) | setV;
      if (stb.wrAlmLo)  almSec[LO_W-1:0]     <= wData[LO_W-1:0];
      if (stb.wrAlmHi)  almSec[SEC_W-1:LO_W] <= wData[HI_W-1:0];
      if (stb.wrAlmDay) almDay               <= wData[DAY_W-1:0];
      if (stb.wrMask)   mask                 <= wData[FLAG_W-1:0];
    end
  end

  always_comb begin
    rData = '0;
    case (addr)
      A_SEC_LO:  rData[LO_W-1:0]   = sec[LO_W-1:0];
      A_SEC_HI:  rData[HI_W-1:0]   = sec[SEC_W-1:LO_W];
      A_DAY:     rData[DAY_W-1:0]  = day;
      A_ALM_LO:  rData[LO_W-1:0]   = almSec[LO_W-1:0];
      A_ALM_HI:  rData[HI_W-1:0]   = almSec[SEC_W-1:LO_W];
      A_ALM_DAY: rData[DAY_W-1:0]  = almDay;
      A_STAT:    rData[FLAG_W-1:0] = flags;
      default:   rData[FLAG_W-1:0] = mask;
    endcase
  end

  assign alarmIrq = flags[0] & mask[0];
  assign tickIrq  = flags[1] & mask[1];
  assign secOut   = sec;
  assign dayOut   = day;
  assign flagOut  = flags;
endmodule

// File: rtl/sec_day_rtc.sv
module sec_day_rtc
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wData,
  input  logic              wEn,
  output logic [DATA_W-1:0] rData,
  output logic              alarmIrq,
  output logic              tickIrq
);
  strobe_t           stb;
  logic [SEC_W-1:0]  secVal;
  logic [DAY_W-1:0]  dayVal;
  logic [FLAG_W-1:0] flagVal;

  rtc_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .addr(addr), .wEn(wEn), .stb(stb)
  );

  rtc_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wData(wData),
    .rData(rData), .secOut(secVal), .dayOut(dayVal), .flagOut(flagVal),
    .alarmIrq(alarmIrq), .tickIrq(tickIrq)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           stb,
  input logic [SEC_W-1:0]  sec,
  input logic [DAY_W-1:0]  day,
  input logic [FLAG_W-1:0] flags,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rData
);
  localparam bit MULTI = (PRESCALE > 1);

  p_day_roll_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick && !stb.wrSecHi && !stb.wrDay && sec == LAST_SEC
    |=> sec == '0 && day == $past(day) + 1'b1);

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrSecHi && !stb.wrSecLo && sec[LO_W-1:0] != 8'hFF && sec < LAST_SEC
    |=> sec[SEC_W-1:LO_W] == $past(sec[SEC_W-1:LO_W]));

  p_lo_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    MULTI && stb.wrSecLo |=> !stb.tick);

  p_alarm_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(stb.tick));

  p_tick_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> flags[1]);

  p_lo_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    addr == A_SEC_LO |-> rData[DATA_W-1:LO_W] == '0);
endmodule

bind sec_day_rtc rtc_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .sec(secVal), .day(dayVal),
  .flags(flagVal), .addr(addr), .rData(rData)
);

// File: tb/sim_sec_day_rtc.sv
`timescale 1ns/1ps
module sim_sec_day_rtc;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wData = 16'd0;
  logic        wEn = 1'b0;
  logic [15:0] rData;
  logic        alarmIrq, tickIrq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_day_rtc #(.PRESCALE(PS)) u0 (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .addr(addr), .wData(wData),
    .wEn(wEn), .rData(rData), .alarmIrq(alarmIrq), .tickIrq(tickIrq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wData = d; wEn = 1'b1;
    @(negedge clk);
    wEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rData;
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    slowEn = 1'b1;
    repeat (n) @(negedge clk);
    slowEn = 1'b0;
  endtask

  task automatic setTime(input logic [15:0] d, input logic [15:0] hi, input logic [15:0] lo);
    wr(3'd2, d);
    wr(3'd1, hi);
    wr(3'd0, lo);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, 16'h0);
    end
    check("R1 alarmIrq after reset", {15'd0, alarmIrq}, 16'h0);
    check("R1 tickIrq after reset", {15'd0, tickIrq}, 16'h0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    pulses(PS);
    rd(3'd0, v); check("R2 one tick after PRESCALE pulses", v, 16'h0001);
    pulses(PS - 1);
    rd(3'd0, v); check("R2 no tick before PRESCALE pulses", v, 16'h0001);
    pulses(1);
    rd(3'd0, v); check("R2 second tick", v, 16'h0002);
  endtask

  task automatic t_carry;
    logic [15:0] v;
    setTime(16'd5, 16'h0000, 16'h00FE);
    pulses(PS);
    rd(3'd0, v); check("R4 low reaches FF", v, 16'h00FF);
    rd(3'd1, v); check("R4 high holds before carry", v, 16'h0000);
    pulses(PS);
    rd(3'd0, v); check("R4 low wraps to 00", v, 16'h0000);
    rd(3'd1, v); check("R4 high increments on carry", v, 16'h0001);
    rd(3'd2, v); check("R4 day unchanged on carry", v, 16'd5);
  endtask

  task automatic t_roll;
    logic [15:0] v;
    setTime(16'd7, 16'h0151, 16'h007F);
    pulses(PS);
    rd(3'd0, v); check("R2 rollover low", v, 16'h0000);
    rd(3'd1, v); check("R2 rollover high", v, 16'h0000);
    rd(3'd2, v); check("R2 rollover day", v, 16'd8);
  endtask

  task automatic t_daywrap;
    logic [15:0] v;
    setTime(16'h7FFF, 16'h0151, 16'h007F);
    rd(3'd2, v); check("R3 max day written", v, 16'h7FFF);
    pulses(PS);
    rd(3'd2, v); check("R3 day wraps to 0", v, 16'h0000);
    rd(3'd1, v); check("R3 high 0 after wrap", v, 16'h0000);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    wr(3'd0, 16'h0010);
    pulses(2);
    wr(3'd0, 16'h0020);
    rd(3'd0, v); check("R5 low write readback", v, 16'h0020);
    pulses(PS - 1);
    rd(3'd0, v); check("R5 prescaler restarted by low write", v, 16'h0020);
    pulses(1);
    rd(3'd0, v); check("R5 tick one second after write", v, 16'h0021);
  endtask

  task automatic t_alarm;
    logic [15:0] v;
    wr(3'd6, 16'h0003);
    wr(3'd7, 16'h0001);
    wr(3'd5, 16'd2);
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'h0005);
    rd(3'd3, v); check("R6 alarm low readback", v, 16'h0005);
    rd(3'd5, v); check("R6 alarm day readback", v, 16'd2);
    setTime(16'd2, 16'h0000, 16'h0003);
    pulses(PS);
    rd(3'd6, v); check("R7 no alarm before match", v & 16'h1, 16'h0);
    check("R7 alarmIrq low before match", {15'd0, alarmIrq}, 16'h0);
    pulses(PS);
    rd(3'd6, v); check("R7 alarm flag on match", v & 16'h1, 16'h1);
    check("R9 alarmIrq with mask", {15'd0, alarmIrq}, 16'h1);
    check("R9 tickIrq masked off", {15'd0, tickIrq}, 16'h0);
    wr(3'd6, 16'h0001);
    rd(3'd6, v); check("R9 write-1 clears alarm flag", v & 16'h1, 16'h0);
    check("R9 alarmIrq drops after clear", {15'd0, alarmIrq}, 16'h0);
    pulses(PS);
    rd(3'd6, v); check("R7 alarm sets only once", v & 16'h1, 16'h0);
  endtask

  task automatic t_tick;
    logic [15:0] v;
    wr(3'd6, 16'h0003);
    wr(3'd7, 16'h0002);
    rd(3'd6, v); check("R9 status cleared", v, 16'h0000);
    pulses(PS);
    rd(3'd6, v); check("R8 update flag on tick", v & 16'h2, 16'h2);
    check("R9 tickIrq with mask", {15'd0, tickIrq}, 16'h1);
    wr(3'd6, 16'h0001);
    rd(3'd6, v); check("R9 writing bit0 leaves update flag", v & 16'h2, 16'h2);
    wr(3'd6, 16'h0002);
    rd(3'd6, v); check("R9 update flag cleared", v, 16'h0000);
    check("R9 tickIrq low after clear", {15'd0, tickIrq}, 16'h0);
  endtask

  task automatic t_width;
    logic [15:0] v;
    wr(3'd0, 16'hFFFF); rd(3'd0, v); check("R10 low width", v, 16'h00FF);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); check("R10 high width", v, 16'h01FF);
    wr(3'd2, 16'hFFFF); rd(3'd2, v); check("R10 day width", v, 16'h7FFF);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); check("R10 alarm high width", v, 16'h01FF);
    wr(3'd7, 16'hFFFF); rd(3'd7, v); check("R10 mask width", v, 16'h0003);
    wr(3'd6, 16'hFFFF); rd(3'd6, v); check("R10 status width", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_carry();
    t_roll();
    t_daywrap();
    t_restart();
    t_alarm();
    t_tick();
    t_width();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule